// File: doc/BRIEF.md
# Staggered Column Power Sequencer

This block moves the analog front-ends of a pixel matrix between a low-power bias and the nominal bias, one column at a time. An external enable starts the sequence. When it rises, the sequencer first spends one cycle with analog power restored and every column still in low power. It then raises the columns to nominal bias in ascending index order, one column every `step_dly_i` cycles. This spreads the supply current step across the ramp instead of taking it in a single edge. When the enable falls with every column at nominal, the columns return to low power in the same ascending order and at the same spacing. If the enable falls part-way through a ramp-up, the ramp turns back: the newest column goes down first and the others follow in descending order. A separate output can cut analog power completely, but only while the sequencer is idle and no column is biased.

The design is one state machine with six named states. `OFF` is idle with all columns in low power. `WAKE` is the single cycle in which power is restored. `RAMP_UP` adds columns. `ON` holds every column at nominal bias. `RAMP_DN` removes columns in order from the lowest index. `ABORT` removes columns in descending order after an interrupted ramp-up. The transitions are as follows:
- OFF→WAKE when the enable is high.
- WAKE→OFF if the enable has already dropped.
- WAKE→RAMP_UP or WAKE→ON (delay 0 or a single column), switching the first column.
- RAMP_UP→ON on the last column.
- RAMP_UP→ABORT or RAMP_UP→OFF when the enable drops.
- ON→RAMP_DN or ON→OFF (delay 0) when the enable drops.
- RAMP_DN→OFF on the last column.
- ABORT→OFF when no column is left.

Two helper modules do the counting and decoding. A delay timer produces the step pulses. A window decoder turns the two column pointers into the per-column bias vector.

Top module: `col_pwr_sequencer`

## Requirements
- R1: While reset is asserted and after it is released, every bit of `col_bias_o` is 0, and `ana_off_o` equals `cut_en_i`.
- R2: Bit i of `col_bias_o` is 1 when column i is at nominal bias and 0 when it is in low power. Suppose the enable is first seen high at a clock edge and `step_dly_i` = D > 0. The cycle after that edge is the wake cycle: all bits are 0 and `ana_off_o` is 0. Column 0 turns on at the next edge. Column k turns on k·D edges after column 0, so the number of columns on is always bits 0..n-1.
- R3: With `step_dly_i` = 0, every column turns on at the edge that ends the wake cycle, and every column turns off at the first edge that sees the enable low while all columns are on.
- R4: When every column is on and the enable is seen low at an edge, column 0 turns off at that edge. Column k turns off k·D edges later. After the last column turns off, the sequencer is idle.
- R5: `ana_off_o` is high only in the idle state and only when `cut_en_i` is 1. It is 0 in the wake cycle and throughout every ramp, and it can rise in the same cycle that the last column turns off.
- R6: Raising the enable during a ramp-down does not change the ramp-down. A new wake cycle starts at the edge after the sequencer returns to idle.
- R7: If the enable is seen low at an edge while k columns are on during a ramp-up (0 < k < N), column k-1 turns off at that edge. Each further column, in descending index order, turns off D edges after the previous one, and the sequencer is idle once no column is on.
- R8: If the enable is low at the edge that ends the wake cycle, the sequencer returns to idle with no column ever switched on.
- R9: With `cut_en_i` at 0, `ana_off_o` stays 0 in every state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_en_i | input | 1 | Power-up request; high asks for nominal bias on all columns |
| step_dly_i | input | DLY_W | Cycles between consecutive column switches; 0 switches all columns at once |
| cut_en_i | input | 1 | Permits a full analog power cut while idle |
| col_bias_o | output | N_COLS | Per-column bias select, 1 = nominal, 0 = low power |
| ana_off_o | output | 1 | Cuts analog supply; high only while idle with every column in low power |

## Verification
The bench sweeps delays 0 to 3 with the power cut both enabled and disabled, and predicts each cycle of the up and down ramps from the step arithmetic. A design that is off by one in the timer would move every column by a cycle. A design that lets the cut signal overlap the wake cycle would show `ana_off_o` high while column 0 is about to rise. The interrupted ramp-up is tried at every column count from 1 to N-1. A design that retraced in ascending order, or that ignored the interruption and finished the ramp-up, would show the wrong bits. Two further cases are covered: a request cancelled in the wake cycle, which must leave every column untouched, and an enable raised part-way through a ramp-down, which must not shorten the ramp or restart it early.

// File: rtl/col_pwr_pkg.sv
package col_pwr_pkg;

    typedef enum logic [2:0] {
        S_OFF     = 3'd0,
        S_WAKE    = 3'd1,
        S_RAMP_UP = 3'd2,
        S_ON      = 3'd3,
        S_RAMP_DN = 3'd4,
        S_ABORT   = 3'd5
    } seq_state_t;

endpackage

// File: rtl/col_step_timer.sv
module col_step_timer #(
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic [DLY_W-1:0] dly_i,
    output logic             step_o
);

    logic [DLY_W-1:0] tmr_q;
    logic [DLY_W-1:0] lim;

    always_comb begin
        lim    = (dly_i == '0) ? '0 : dly_i - DLY_W'(1);
        step_o = (dly_i == '0) || (tmr_q >= lim);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else if (clr_i || step_o) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_q + DLY_W'(1);
        end
    end

endmodule

// File: rtl/col_window_decode.sv
module col_window_decode #(
    parameter int N_COLS = 8,
    parameter int PTR_W  = $clog2(N_COLS + 1)
) (
    input  logic [PTR_W-1:0]  lo_i,
    input  logic [PTR_W-1:0]  hi_i,
    output logic [N_COLS-1:0] bias_o
);

    for (genvar gi = 0; gi < N_COLS; gi++) begin : g_col
        localparam logic [PTR_W-1:0] IDX = PTR_W'(gi);
        assign bias_o[gi] = (IDX >= lo_i) && (IDX < hi_i);
    end

endmodule

// File: rtl/col_pwr_fsm.sv
module col_pwr_fsm
    import col_pwr_pkg::*;
#(
    parameter int N_COLS = 8,
    parameter int DLY_W  = 4,
    parameter int PTR_W  = $clog2(N_COLS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             zero_dly_i,
    input  logic             step_i,
    input  logic             cut_i,
    output logic             tmr_clr_o,
    output logic [PTR_W-1:0] lo_o,
    output logic [PTR_W-1:0] hi_o,
    output logic             ana_off_o
);

    localparam logic [PTR_W-1:0] FULL = PTR_W'(N_COLS);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(N_COLS - 1);
    localparam logic [PTR_W-1:0] ONE  = PTR_W'(1);
    localparam logic             SINGLE = (N_COLS == 1);

    seq_state_t       state_q, state_d;
    logic [PTR_W-1:0] hi_q, hi_d;
    logic [PTR_W-1:0] lo_q, lo_d;
    logic             clr_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_OFF;
            hi_q    <= '0;
            lo_q    <= '0;
        end else begin
            state_q <= state_d;
            hi_q    <= hi_d;
            lo_q    <= lo_d;
        end
    end

    always_comb begin
        state_d = state_q;
        hi_d    = hi_q;
        lo_d    = lo_q;
        clr_d   = 1'b1;
        unique case (state_q)
            S_OFF: begin
                if (en_i) state_d = S_WAKE;
            end
            S_WAKE: begin
                if (!en_i) begin
                    state_d = S_OFF;
                end else if (zero_dly_i || SINGLE) begin
                    hi_d    = FULL;
                    state_d = S_ON;
                end else begin
                    hi_d    = ONE;
                    state_d = S_RAMP_UP;
                end
            end
            S_RAMP_UP: begin
                if (!en_i) begin
                    hi_d    = hi_q - ONE;
                    state_d = (hi_q == ONE) ? S_OFF : S_ABORT;
                end else begin
                    clr_d = 1'b0;
                    if (step_i) begin
                        if (zero_dly_i || hi_q == LAST) begin
                            hi_d    = FULL;
                            state_d = S_ON;
                        end else begin
                            hi_d = hi_q + ONE;
                        end
                    end
                end
            end
            S_ON: begin
                if (!en_i) begin
                    if (zero_dly_i || SINGLE) begin
                        hi_d    = '0;
                        lo_d    = '0;
                        state_d = S_OFF;
                    end else begin
                        lo_d    = ONE;
                        state_d = S_RAMP_DN;
                    end
                end
            end
            S_RAMP_DN: begin
                clr_d = 1'b0;
                if (step_i) begin
                    if (zero_dly_i || lo_q == LAST) begin
                        hi_d    = '0;
                        lo_d    = '0;
                        state_d = S_OFF;
                    end else begin
                        lo_d = lo_q + ONE;
                    end
                end
            end
            S_ABORT: begin
                clr_d = 1'b0;
                if (step_i) begin
                    if (zero_dly_i || hi_q == ONE) begin
                        hi_d    = '0;
                        state_d = S_OFF;
                    end else begin
                        hi_d = hi_q - ONE;
                    end
                end
            end
            default: begin
                state_d = S_OFF;
                hi_d    = '0;
                lo_d    = '0;
            end
        endcase
    end

    always_comb begin
        tmr_clr_o = clr_d;
        lo_o      = lo_q;
        hi_o      = hi_q;
        ana_off_o = (state_q == S_OFF) && cut_i;
    end

endmodule

// File: rtl/col_pwr_sequencer.sv
module col_pwr_sequencer #(
    parameter int N_COLS = 8,
    parameter int DLY_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_en_i,
    input  logic [DLY_W-1:0]  step_dly_i,
    input  logic              cut_en_i,
    output logic [N_COLS-1:0] col_bias_o,
    output logic              ana_off_o
);

    localparam int PTR_W = $clog2(N_COLS + 1);

    logic             step;
    logic             tmr_clr;
    logic             zero_dly;
    logic [PTR_W-1:0] lo_ptr;
    logic [PTR_W-1:0] hi_ptr;

    assign zero_dly = (step_dly_i == '0);

    col_step_timer #(
        .DLY_W (DLY_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (tmr_clr),
        .dly_i  (step_dly_i),
        .step_o (step)
    );

    col_pwr_fsm #(
        .N_COLS (N_COLS),
        .DLY_W  (DLY_W),
        .PTR_W  (PTR_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (pwr_en_i),
        .zero_dly_i (zero_dly),
        .step_i     (step),
        .cut_i      (cut_en_i),
        .tmr_clr_o  (tmr_clr),
        .lo_o       (lo_ptr),
        .hi_o       (hi_ptr),
        .ana_off_o  (ana_off_o)
    );

    col_window_decode #(
        .N_COLS (N_COLS),
        .PTR_W  (PTR_W)
    ) u_decode (
        .lo_i   (lo_ptr),
        .hi_i   (hi_ptr),
        .bias_o (col_bias_o)
    );

endmodule

// File: rtl/col_pwr_sequencer_chk.sv
module col_pwr_sequencer_chk #(
    parameter int N_COLS = 8,
    parameter int DLY_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwr_en_i,
    input logic [DLY_W-1:0]  step_dly_i,
    input logic              cut_en_i,
    input logic [N_COLS-1:0] col_bias_o,
    input logic              ana_off_o
);

    int ones_now;
    assign ones_now = $countones(col_bias_o);

    AST_STEP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(step_dly_i) != '0) |->
            (ones_now <= $past(ones_now) + 1) && (ones_now + 1 >= $past(ones_now))); // R2

    AST_CUT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        ana_off_o |-> (col_bias_o == '0)); // R5

    AST_WAKE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(col_bias_o[0]) |-> !$past(ana_off_o)); // R5

    AST_RISE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (ones_now > $past(ones_now)) |-> $past(pwr_en_i)); // R8

    AST_NO_CUT_WHEN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !cut_en_i |-> !ana_off_o); // R9

endmodule

bind col_pwr_sequencer col_pwr_sequencer_chk #(
    .N_COLS (N_COLS),
    .DLY_W  (DLY_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_en_i   (pwr_en_i),
    .step_dly_i (step_dly_i),
    .cut_en_i   (cut_en_i),
    .col_bias_o (col_bias_o),
    .ana_off_o  (ana_off_o)
);

// File: tb/col_pwr_sequencer_tb.sv
module col_pwr_sequencer_tb;

    localparam int NC = 8;
    localparam int DW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pwr_en = 1'b0;
    logic [DW-1:0] dly = '0;
    logic          cut = 1'b1;
    logic [NC-1:0] bias;
    logic          aoff;

    int vecs = 0;
    int errs = 0;

    always #2.5 clk = ~clk;

    col_pwr_sequencer #(.N_COLS(NC), .DLY_W(DW)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_en_i   (pwr_en),
        .step_dly_i (dly),
        .cut_en_i   (cut),
        .col_bias_o (bias),
        .ana_off_o  (aoff)
    );

    function automatic logic [NC-1:0] low_mask(input int c);
        logic [NC-1:0] m = '0;
        for (int i = 0; i < NC; i++) if (i < c) m[i] = 1'b1;
        return m;
    endfunction

    function automatic int min_i(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    task automatic chk(input logic [NC-1:0] eb, input logic eo, input string req);
        vecs++;
        if (bias !== eb || aoff !== eo) begin
            errs++;
            $display("FAIL %s: bias=%b off=%b expected bias=%b off=%b", req, bias, aoff, eb, eo);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // ramp up to full on; leaves bench at negedge with all columns on
    task automatic ramp_up(input int d, input string req);
        int last_j;
        pwr_en = 1'b1;
        step();
        chk('0, 1'b0, "R5");
        last_j = (d == 0) ? 2 : 1 + (NC - 1) * d + 1;
        for (int j = 1; j <= last_j; j++) begin
            int c;
            step();
            c = (d == 0) ? NC : min_i(NC, 1 + (j - 1) / d);
            chk(low_mask(c), 1'b0, req);
        end
    endtask

    initial begin
        #1_000_000;
        errs++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        // R1 reset state
        @(negedge clk);
        @(negedge clk);
        chk('0, 1'b1, "R1");
        rst_n = 1'b1;
        step();
        chk('0, 1'b1, "R1");
        cut = 1'b0;
        step();
        chk('0, 1'b0, "R1");

        // R2 R3 R4 R5 R9 sweep
        for (int d = 0; d < 4; d++) begin
            for (int cv = 0; cv < 2; cv++) begin
                int last_m;
                dly = DW'(d);
                cut = cv[0];
                step();
                chk('0, cut, cut ? "R5" : "R9");
                ramp_up(d, (d == 0) ? "R3" : "R2");
                pwr_en = 1'b0;
                last_m = (d == 0) ? 2 : 1 + (NC - 1) * d + 2;
                for (int m = 1; m <= last_m; m++) begin
                    int o;
                    logic [NC-1:0] eb;
                    step();
                    o  = (d == 0) ? NC : 1 + (m - 1) / d;
                    eb = (o >= NC) ? '0 : ~low_mask(o);
                    chk(eb, cut && (eb == '0), (d == 0) ? "R3" : "R4");
                end
                step();
                chk('0, cut, cut ? "R5" : "R9");
            end
        end

        // R7 interrupted ramp-up at every count
        cut = 1'b1;
        for (int d = 1; d < 4; d++) begin
            for (int k = 1; k < NC; k++) begin
                int jk;
                dly = DW'(d);
                pwr_en = 1'b1;
                step();
                chk('0, 1'b0, "R5");
                jk = 1 + (k - 1) * d;
                for (int j = 1; j <= jk; j++) begin
                    step();
                    chk(low_mask(1 + (j - 1) / d), 1'b0, "R2");
                end
                pwr_en = 1'b0;
                for (int m = 1; m <= 1 + (k - 1) * d + 1; m++) begin
                    int c;
                    logic [NC-1:0] eb;
                    step();
                    c  = k - 1 - (m - 1) / d;
                    if (c < 0) c = 0;
                    eb = low_mask(c);
                    chk(eb, (eb == '0), "R7");
                end
            end
        end

        // R8 cancel in wake cycle
        for (int cv = 0; cv < 2; cv++) begin
            cut = cv[0];
            dly = DW'(2);
            pwr_en = 1'b1;
            step();
            chk('0, 1'b0, "R8");
            pwr_en = 1'b0;
            step();
            chk('0, cut, "R8");
            step();
            chk('0, cut, "R8");
        end

        // R6 enable raised mid ramp-down
        cut = 1'b1;
        dly = DW'(2);
        ramp_up(2, "R2");
        pwr_en = 1'b0;
        for (int m = 1; m <= 1 + (NC - 1) * 2; m++) begin
            int o;
            logic [NC-1:0] eb;
            step();
            if (m == 2) pwr_en = 1'b1;
            o  = 1 + (m - 1) / 2;
            eb = (o >= NC) ? '0 : ~low_mask(o);
            chk(eb, (eb == '0), "R6");
        end
        step();
        chk('0, 1'b0, "R6");
        step();
        chk(low_mask(1), 1'b0, "R6");
        pwr_en = 1'b0;
        step();
        chk('0, 1'b1, "R7");

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule